// File: doc/BRIEF.md
# Twisted-pair link integrity monitor

This block watches the receive side of one or more twisted-pair repeater ports and decides, for each port, whether the link is usable. Each port is in one of two states: link-pass or link-fail. The port-enable output is high only in link-pass. The repeater uses it to gate the port's transmit and receive paths. Pulse qualification and decoding happen upstream. The block therefore sees each received link test pulse, and the start of each received packet, as a one-cycle strobe.

A port drops to link-fail when nothing at all has been received for a long silence window. A port in link-fail recovers on a single packet, or on a run of four link pulses that no silence expiry interrupts. A management mask per port turns off receive checking, so that the port is held in link-pass. Independently of all this, each port emits a one-cycle link pulse request whenever its transmitter has been idle for a shorter interval. This happens in every state.

The timer lengths are parameters. The defaults assume a 20 MHz reference: 100 ms for link loss and 16 ms for the idle interval. A bench shortens both.

Top module: `tp_link_guard`

## Requirements
- R1: With checking enabled, a port in link-pass whose last receive event was sampled at clock edge E goes to link-fail at edge E+LOSS_TICKS if no pulse or packet arrives in between. A port that is in link-pass after reset and has never received anything fails LOSS_TICKS edges after reset release.
- R2: Bit p of `port_en` is 1 exactly when port p is in link-pass. It is 0 in link-fail.
- R3: A port in link-fail enters link-pass at the edge that samples a packet strobe. It also enters link-pass at the edge that samples the fourth link pulse counted since the count last restarted. A packet and a pulse in the same cycle count as a packet.
- R4: While `tx_active` of a port is low, that port emits a link pulse every IDLE_TICKS cycles. A high `tx_active` restarts the idle interval and suppresses pulses. The first pulse appears IDLE_TICKS edges after the last edge that sampled `tx_active` high.
- R5: Link pulse emission does not depend on link state or on `check_en`. It runs with the same period in link-fail, in link-pass and with checking masked.
- R6: When `check_en` of a port is low, the port is in link-pass one edge later and does not enter link-fail for as long as the mask stays low.
- R7: After reset every port is in link-fail with its pulse count at zero. All `port_en` and `link_pulse` bits are 0.
- R8: In link-fail, a silence expiry restarts the pulse count at zero, so pulses spread across an expiry do not add up. A packet strobe also restarts the count.
- R9: Each `link_pulse` assertion lasts exactly one clock cycle.
- R10: Ports are independent: events on one port never change another port's `port_en` or `link_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| check_en | input | NUM_PORTS | Per-port receive link check enable (0 masks checking) |
| rx_pulse | input | NUM_PORTS | One-cycle strobe: a valid link test pulse was received |
| rx_packet | input | NUM_PORTS | One-cycle strobe: a received packet started |
| tx_active | input | NUM_PORTS | High while the port's transmitter is sending data |
| port_en | output | NUM_PORTS | High when the port is in link-pass; gates the repeater paths |
| link_pulse | output | NUM_PORTS | One-cycle request to transmit a link test pulse |

## Verification
The assertions take every input as synchronous to `clk`. They treat receive strobes as cycle-level events, so a strobe held for several cycles counts as one event per cycle. They also require IDLE_TICKS and RECOVER_PULSES to be at least two, so that a pulse strobe can be followed by a low cycle. The bench changes inputs only on the falling edge, raises each receive strobe for a single cycle, and shortens the timers to 40 and 12 cycles. It places gaps clearly inside or outside the silence window, so that every expected change of state falls on a known edge.

// File: rtl/tplg_pkg.sv
// Shared definitions for the twisted-pair link integrity monitor.
// Assumes a 20 MHz reference when the default timer lengths are used.
package tplg_pkg;

    typedef enum logic {
        LINK_FAIL = 1'b0,
        LINK_PASS = 1'b1
    } link_state_e;

    localparam int REF_CLK_HZ          = 20_000_000;
    localparam int DEFAULT_LOSS_TICKS  = REF_CLK_HZ / 10;          // 100 ms
    localparam int DEFAULT_IDLE_TICKS  = (REF_CLK_HZ / 1000) * 16; // 16 ms
    localparam int DEFAULT_RECOVER_CNT = 4;

endpackage

// File: rtl/tplg_interval_timer.sv
// Restartable terminal-count timer.
// After a restart, expire is high in the cycle when TICKS-1 further cycles
// have passed without a restart. The count then wraps to zero on its own.
// Assumes TICKS >= 2. A restart in the same cycle takes priority over expiry.
module tplg_interval_timer #(
    parameter int TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expire
);
    localparam int CW = (TICKS > 2) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    assign expire = !restart && (cnt_q == LAST);

    // Advance the count, clear it on restart, and wrap it on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // After a restart the timer cannot expire in the next cycle.
    assert_restart_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !expire);

endmodule

// File: rtl/tplg_rx_monitor.sv
// Receive-side link state for one port.
// It tracks link-pass / link-fail from received pulse and packet strobes and
// a silence timer. Assumes the strobes are synchronous and already qualified.
// A masked check forces link-pass.
module tplg_rx_monitor
    import tplg_pkg::*;
#(
    parameter int LOSS_TICKS     = DEFAULT_LOSS_TICKS,
    parameter int RECOVER_PULSES = DEFAULT_RECOVER_CNT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic check_en,
    input  logic rx_pulse,
    input  logic rx_packet,
    output logic port_en
);
    localparam int PCW = (RECOVER_PULSES > 2) ? $clog2(RECOVER_PULSES) : 1;
    localparam logic [PCW-1:0] LAST_PULSE = PCW'(RECOVER_PULSES - 1);

    link_state_e   state_q, state_d;
    logic [PCW-1:0] pcnt_q, pcnt_d;
    logic          rx_event;
    logic          silence_expire;

    assign rx_event = rx_pulse || rx_packet;

    tplg_interval_timer #(.TICKS(LOSS_TICKS)) u_silence (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (rx_event),
        .expire  (silence_expire)
    );

    // Choose the next link state and pulse count.
    always_comb begin
        state_d = state_q;
        pcnt_d  = pcnt_q;
        if (!check_en) begin
            state_d = LINK_PASS;
            pcnt_d  = '0;
        end else if (state_q == LINK_PASS) begin
            if (silence_expire) begin
                state_d = LINK_FAIL;
                pcnt_d  = '0;
            end
        end else begin
            if (rx_packet) begin
                state_d = LINK_PASS;
                pcnt_d  = '0;
            end else if (rx_pulse) begin
                if (pcnt_q == LAST_PULSE) begin
                    state_d = LINK_PASS;
                    pcnt_d  = '0;
                end else begin
                    pcnt_d = pcnt_q + 1'b1;
                end
            end else if (silence_expire) begin
                pcnt_d = '0;
            end
        end
    end

    // Hold the link state and the pulse count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LINK_FAIL;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            pcnt_q  <= pcnt_d;
        end
    end

    assign port_en = (state_q == LINK_PASS);

    assert_silence_fails_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (check_en && port_en && silence_expire) |=> !port_en);

    assert_no_spurious_recovery_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (check_en && !port_en && !rx_packet && !(rx_pulse && pcnt_q == LAST_PULSE))
            |=> !port_en);

    assert_packet_recovers_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (check_en && rx_packet) |=> port_en);

    assert_masked_never_fails_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !check_en |=> port_en);

    assert_expiry_restarts_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (check_en && !port_en && silence_expire) |=> (pcnt_q == '0));

    assert_packet_restarts_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_packet |=> (pcnt_q == '0));

endmodule

// File: rtl/tplg_tx_pulser.sv
// Link pulse scheduler for one port.
// It requests a one-cycle link pulse each time the transmitter has been idle
// for IDLE_TICKS cycles, whatever the link state. Assumes IDLE_TICKS >= 2.
module tplg_tx_pulser
    import tplg_pkg::*;
#(
    parameter int IDLE_TICKS = DEFAULT_IDLE_TICKS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active,
    output logic link_pulse
);
    logic idle_expire;
    logic pulse_q;

    tplg_interval_timer #(.TICKS(IDLE_TICKS)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tx_active),
        .expire  (idle_expire)
    );

    // Register the pulse request so that the output has no combinational path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= idle_expire;
        end
    end

    assign link_pulse = pulse_q;

    assert_quiet_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |=> !link_pulse);

    assert_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        link_pulse |=> !link_pulse);

endmodule

// File: rtl/tp_link_guard.sv
// Multi-port twisted-pair link integrity monitor.
// Each port has its own receive link state machine and its own link pulse
// scheduler. Ports share only the clock and the reset. All inputs are
// synchronous to clk.
module tp_link_guard
    import tplg_pkg::*;
#(
    parameter int NUM_PORTS      = 8,
    parameter int LOSS_TICKS     = DEFAULT_LOSS_TICKS,
    parameter int IDLE_TICKS     = DEFAULT_IDLE_TICKS,
    parameter int RECOVER_PULSES = DEFAULT_RECOVER_CNT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] check_en,
    input  logic [NUM_PORTS-1:0] rx_pulse,
    input  logic [NUM_PORTS-1:0] rx_packet,
    input  logic [NUM_PORTS-1:0] tx_active,
    output logic [NUM_PORTS-1:0] port_en,
    output logic [NUM_PORTS-1:0] link_pulse
);
    // One receive monitor and one pulse scheduler per port.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        tplg_rx_monitor #(
            .LOSS_TICKS     (LOSS_TICKS),
            .RECOVER_PULSES (RECOVER_PULSES)
        ) u_rx (
            .clk       (clk),
            .rst_n     (rst_n),
            .check_en  (check_en[p]),
            .rx_pulse  (rx_pulse[p]),
            .rx_packet (rx_packet[p]),
            .port_en   (port_en[p])
        );

        tplg_tx_pulser #(
            .IDLE_TICKS (IDLE_TICKS)
        ) u_tx (
            .clk        (clk),
            .rst_n      (rst_n),
            .tx_active  (tx_active[p]),
            .link_pulse (link_pulse[p])
        );
    end

    assert_reset_quiet_R7: assert property (@(posedge clk)
        !rst_n |=> (port_en == '0 && link_pulse == '0));

endmodule

// File: tb/tp_link_guard_test.sv
`timescale 1ns/1ps
module tp_link_guard_test;
    localparam int NP   = 2;
    localparam int LOSS = 40;
    localparam int IDLE = 12;
    localparam int REC  = 4;
    localparam int NV   = 18;

    logic clk = 1'b0;
    logic rst_n;
    logic [NP-1:0] check_en, rx_pulse, rx_packet, tx_active;
    logic [NP-1:0] port_en, link_pulse;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #4 clk = ~clk;

    tp_link_guard #(
        .NUM_PORTS(NP), .LOSS_TICKS(LOSS), .IDLE_TICKS(IDLE), .RECOVER_PULSES(REC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .check_en(check_en), .rx_pulse(rx_pulse),
        .rx_packet(rx_packet), .tx_active(tx_active), .port_en(port_en),
        .link_pulse(link_pulse)
    );

    // Vector fields: [8] pulse, [7] packet, [6:1] idle cycles after the strobe, [0] expected port_en[0]
    localparam logic [8:0] VEC [NV] = '{
        {1'b1, 1'b0, 6'd5,  1'b0},  // R3 pulse 1
        {1'b1, 1'b0, 6'd5,  1'b0},  // pulse 2
        {1'b1, 1'b0, 6'd5,  1'b0},  // pulse 3
        {1'b1, 1'b0, 6'd5,  1'b1},  // R3 pulse 4 recovers
        {1'b0, 1'b0, 6'd45, 1'b0},  // R1 silence fails
        {1'b0, 1'b1, 6'd5,  1'b1},  // R3 packet recovers
        {1'b1, 1'b0, 6'd30, 1'b1},  // pulses keep the link alive
        {1'b1, 1'b0, 6'd30, 1'b1},
        {1'b0, 1'b0, 6'd45, 1'b0},  // R1
        {1'b1, 1'b0, 6'd5,  1'b0},
        {1'b1, 1'b0, 6'd5,  1'b0},
        {1'b1, 1'b0, 6'd45, 1'b0},  // R8 expiry after 3 pulses
        {1'b1, 1'b0, 6'd5,  1'b0},  // R8 count restarted
        {1'b1, 1'b0, 6'd5,  1'b0},
        {1'b1, 1'b0, 6'd5,  1'b0},
        {1'b1, 1'b0, 6'd5,  1'b1},  // R3 fourth consecutive
        {1'b0, 1'b0, 6'd45, 1'b0},  // R1
        {1'b1, 1'b1, 6'd5,  1'b1}   // R3 pulse and packet together
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Finds a pulse, checks its width and checks the distance to the next pulse.
    task automatic measure(input int p, input string req);
        int  k;
        bit  seen;
        seen = 1'b0;
        for (int i = 0; i < 3 * IDLE && !seen; i++) begin
            @(negedge clk);
            if (link_pulse[p]) seen = 1'b1;
        end
        chk({req, " pulse present"}, 32'(seen), 32'd1);
        @(negedge clk);
        chk("R9 pulse width one cycle", 32'(link_pulse[p]), 32'd0);
        k = 1;
        while (!link_pulse[p] && k < 3 * IDLE) begin
            @(negedge clk);
            k++;
        end
        chk({req, " pulse period"}, 32'(k), 32'(IDLE));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int k;
        bit any_low;
        bit any_pulse;
        rst_n     = 1'b0;
        check_en  = '1;
        rx_pulse  = '0;
        rx_packet = '0;
        tx_active = 2'b01;       // port 0 transmitter kept busy
        repeat (5) @(negedge clk);
        chk("R7 reset port_en", 32'(port_en), 32'd0);
        chk("R7 reset link_pulse", 32'(link_pulse), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 link-fail after reset", 32'(port_en), 32'd0);

        // Table walk on port 0; port 1 stays silent (R10)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            rx_pulse[0]  = VEC[i][8];
            rx_packet[0] = VEC[i][7];
            @(negedge clk);
            rx_pulse[0]  = 1'b0;
            rx_packet[0] = 1'b0;
            repeat (int'(VEC[i][6:1])) @(negedge clk);
            chk($sformatf("R2 R1 R3 R8 step %0d port_en", i), 32'(port_en[0]), 32'(VEC[i][0]));
            chk("R10 silent port unaffected", 32'(port_en[1]), 32'd0);
        end

        // R1 / R6: masking checking holds the port in link-pass
        repeat (LOSS + 5) @(negedge clk);
        chk("R1 silence after packet", 32'(port_en[0]), 32'd0);
        check_en[0] = 1'b0;
        @(negedge clk);
        chk("R6 mask forces pass", 32'(port_en[0]), 32'd1);
        any_low = 1'b0;
        for (int i = 0; i < 3 * LOSS; i++) begin
            @(negedge clk);
            if (!port_en[0]) any_low = 1'b1;
        end
        chk("R6 masked port never fails", 32'(any_low), 32'd0);
        check_en[0] = 1'b1;
        repeat (LOSS + 3) @(negedge clk);
        chk("R1 fails again once unmasked", 32'(port_en[0]), 32'd0);

        // R4 R5: pulses on port 1 while in link-fail, then while masked
        measure(1, "R5 link-fail");
        check_en[1] = 1'b0;
        @(negedge clk);
        chk("R6 port 1 pass", 32'(port_en[1]), 32'd1);
        chk("R10 port 0 unaffected by port 1 mask", 32'(port_en[0]), 32'd0);
        measure(1, "R5 masked pass");

        // R4: busy transmitter on port 0 never pulses
        any_pulse = 1'b0;
        for (int i = 0; i < 3 * IDLE; i++) begin
            @(negedge clk);
            if (link_pulse[0]) any_pulse = 1'b1;
        end
        chk("R4 no pulse while transmitting", 32'(any_pulse), 32'd0);

        // R4: activity restarts the idle interval on port 1
        @(negedge clk);
        tx_active[1] = 1'b1;
        any_pulse = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (link_pulse[1]) any_pulse = 1'b1;
        end
        chk("R4 activity suppresses pulses", 32'(any_pulse), 32'd0);
        tx_active[1] = 1'b0;
        k = 0;
        while (!link_pulse[1] && k < 3 * IDLE) begin
            @(negedge clk);
            k++;
        end
        chk("R4 first pulse after activity", 32'(k), 32'(IDLE));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule